// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps the time of day and the date as packed BCD digit fields and moves them forward by one second each time a one-second enable pulse arrives. Seconds, minutes and hours sit in a 22-bit time word. Day, month and a two-digit year sit in a 24-bit calendar word. A small day-of-week counter runs beside them. A leap-year flag is decoded from the year. Software can overwrite the time word, or the calendar word together with the day of week, through load strobes.

An input selects 24-hour counting or 12-hour counting. In 12-hour mode the upper bit of the tens-of-hours field is the afternoon indicator. Carries are not resolved in a single cycle. A ripple sequencer visits one field per clock, and the named states are these:
- SQ_IDLE waits for a tick.
- SQ_SEC steps seconds.
- SQ_MIN steps minutes.
- SQ_HOUR steps hours.
- SQ_DAY steps the day and the day of week.
- SQ_MON steps the month.
- SQ_YEAR steps the year.

The transitions are:
- tick_accept: SQ_IDLE goes to SQ_SEC.
- carry_up: any stepping state goes to the next one when its field wraps.
- settle: a stepping state returns to SQ_IDLE when its field does not wrap, and SQ_YEAR always returns to SQ_IDLE.
- load_abort: any state goes to SQ_IDLE when a load strobe is high.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the time word is 0x000000, the calendar word is 0x000101 (day 01, month 01, year 00), the day of week is 0 and the leap flag is 1.
- R2: A time load stores the load word, with bits 7 and 15 forced to 0, on the next clock. A calendar load stores the load word, with bits 7:6 and 15:13 forced to 0, and the day-of-week value on the next clock. The time fields are: seconds ones 3:0, seconds tens 6:4, minutes ones 11:8, minutes tens 14:12, hours ones 19:16, hours tens 21:20. The calendar fields are: day ones 3:0, day tens 5:4, month ones 11:8, month tens bit 12, year ones 19:16, year tens 23:20.
- R3: A load strobe in the same cycle as a tick wins, and the tick is discarded. A load also abandons any carry ripple still in progress.
- R4: A tick sampled on a clock edge changes the seconds field on the following edge. Each further carry takes one more clock, so every field has settled within 7 clocks of the tick.
- R5: Seconds and minutes count 00 to 59 in BCD. A wrap from 59 to 00 carries into the next field.
- R6: With hour_mode_24 = 1 the hour counts 00 to 23. A step from 23 goes to 00 and advances the date.
- R7: With hour_mode_24 = 0, bit 21 is the afternoon flag (1 = PM) and bits 20:16 hold an hour that runs 12, 01, …, 11. A step from 11 goes to 12 and toggles the flag. A step from 12 goes to 01. The date advances only when the step is from PM 11.
- R8: Days per month are 31, except months 04, 06, 09 and 11, which have 30. February has 28 days, or 29 in a leap year. After the last day the day becomes 01 and the month advances.
- R9: The leap flag is 1 exactly when the two-digit year is divisible by 4, counting 00.
- R10: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R11: The day of week advances by one with every date advance and wraps from DOW_COUNT-1 to 0.
- R12: A tick that arrives while a carry ripple is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-second enable pulse |
| hour_mode_24 | input | 1 | 1 = 24-hour counting, 0 = 12-hour counting |
| time_ld | input | 1 | Time word load strobe |
| time_ld_word | input | 22 | Time word to load |
| cal_ld | input | 1 | Calendar and day-of-week load strobe |
| cal_ld_word | input | 24 | Calendar word to load |
| dow_ld_val | input | DOW_W | Day-of-week value to load |
| time_now | output | 22 | Current time word |
| cal_now | output | 24 | Current calendar word |
| dow_now | output | DOW_W | Current day of week |
| leap_year | output | 1 | 1 when the current year is a leap year |

## Verification
The bench builds the block with its default DOW_COUNT of 7, so DOW_W is 3. With that setting the wrap of the day of week from 6 to 0 occurs within a few loads, and it meets the year, month and midnight carries in a single tick. Randomly loaded values are biased toward 59 seconds, 59 minutes, the last hour, the last day of the month, month 12 and year 99. This lets one tick walk the ripple through every sequencer state in both hour modes and across leap and common Februaries.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;

    localparam int TW = 22;
    localparam int CW = 24;
    localparam logic [TW-1:0] TIME_MASK = 22'h3F7F7F;
    localparam logic [CW-1:0] CAL_MASK  = 24'hFF1F3F;
    localparam logic [CW-1:0] CAL_RESET = 24'h000101;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SEC,
        SQ_MIN,
        SQ_HOUR,
        SQ_DAY,
        SQ_MON,
        SQ_YEAR
    } seq_state_e;

    // two-digit BCD increment, ones digit wraps at 9
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // divisible-by-4 test on a BCD year
    function automatic logic bcd_leap(input logic [7:0] yr);
        if (yr[4])
            return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
        else
            return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    endfunction

    function automatic logic [7:0] last_day_of(input logic [7:0] mon, input logic leap);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_tick_seq.sv
module rtc_tick_seq
    import rtc_bcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       load_any,
    input  logic       sec_wrap,
    input  logic       min_wrap,
    input  logic       hour_wrap,
    input  logic       day_wrap,
    input  logic       mon_wrap,
    output logic       step_sec,
    output logic       step_min,
    output logic       step_hour,
    output logic       step_day,
    output logic       step_mon,
    output logic       step_year,
    output seq_state_e state_o
);

    seq_state_e state_q;
    seq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= SQ_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: if (tick) state_d = SQ_SEC;
            SQ_SEC:  state_d = sec_wrap  ? SQ_MIN  : SQ_IDLE;
            SQ_MIN:  state_d = min_wrap  ? SQ_HOUR : SQ_IDLE;
            SQ_HOUR: state_d = hour_wrap ? SQ_DAY  : SQ_IDLE;
            SQ_DAY:  state_d = day_wrap  ? SQ_MON  : SQ_IDLE;
            SQ_MON:  state_d = mon_wrap  ? SQ_YEAR : SQ_IDLE;
            SQ_YEAR: state_d = SQ_IDLE;
            default: state_d = SQ_IDLE;
        endcase
        if (load_any)
            state_d = SQ_IDLE;
    end

    always_comb begin
        step_sec  = 1'b0;
        step_min  = 1'b0;
        step_hour = 1'b0;
        step_day  = 1'b0;
        step_mon  = 1'b0;
        step_year = 1'b0;
        if (!load_any) begin
            unique case (state_q)
                SQ_SEC:  step_sec  = 1'b1;
                SQ_MIN:  step_min  = 1'b1;
                SQ_HOUR: step_hour = 1'b1;
                SQ_DAY:  step_day  = 1'b1;
                SQ_MON:  step_mon  = 1'b1;
                SQ_YEAR: step_year = 1'b1;
                default: ;
            endcase
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/rtc_clock_word.sv
module rtc_clock_word
    import rtc_bcd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode24,
    input  logic          ld,
    input  logic [TW-1:0] ld_word,
    input  logic          step_sec,
    input  logic          step_min,
    input  logic          step_hour,
    output logic [TW-1:0] word,
    output logic          sec_wrap,
    output logic          min_wrap,
    output logic          hour_wrap
);

    logic [TW-1:0] word_q;
    logic [7:0]    sec_f;
    logic [7:0]    min_f;
    logic [7:0]    hr24_f;
    logic [7:0]    hr12_f;
    logic          pm_q;
    logic [5:0]    hr_next;

    assign sec_f  = {1'b0, word_q[6:0]};
    assign min_f  = {1'b0, word_q[14:8]};
    assign hr24_f = {2'b00, word_q[21:16]};
    assign hr12_f = {3'b000, word_q[20:16]};
    assign pm_q   = word_q[21];

    assign sec_wrap = (sec_f == 8'h59);
    assign min_wrap = (min_f == 8'h59);

    always_comb begin
        hour_wrap = 1'b0;
        hr_next   = 6'(bcd_inc(hr24_f));
        if (mode24) begin
            if (hr24_f == 8'h23) begin
                hour_wrap = 1'b1;
                hr_next   = 6'h00;
            end
        end else if (hr12_f == 8'h11) begin
            hour_wrap = pm_q;
            hr_next   = {~pm_q, 5'h12};
        end else if (hr12_f == 8'h12) begin
            hr_next   = {pm_q, 5'h01};
        end else begin
            hr_next   = {pm_q, 5'(bcd_inc(hr12_f))};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (ld) begin
            word_q <= ld_word & TIME_MASK;
        end else begin
            if (step_sec)
                word_q[6:0] <= sec_wrap ? 7'h00 : 7'(bcd_inc(sec_f));
            if (step_min)
                word_q[14:8] <= min_wrap ? 7'h00 : 7'(bcd_inc(min_f));
            if (step_hour)
                word_q[21:16] <= hr_next;
        end
    end

    assign word = word_q;

endmodule

// File: rtl/rtc_date_word.sv
module rtc_date_word
    import rtc_bcd_pkg::*;
#(
    parameter int DOW_COUNT = 7,
    parameter int DOW_W     = $clog2(DOW_COUNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [CW-1:0]    ld_word,
    input  logic [DOW_W-1:0] ld_dow,
    input  logic             step_day,
    input  logic             step_mon,
    input  logic             step_year,
    output logic [CW-1:0]    word,
    output logic [DOW_W-1:0] dow,
    output logic             leap,
    output logic             day_wrap,
    output logic             mon_wrap
);

    localparam logic [DOW_W-1:0] DOW_LAST = DOW_W'(DOW_COUNT - 1);

    logic [CW-1:0]    word_q;
    logic [DOW_W-1:0] dow_q;
    logic [7:0]       day_f;
    logic [7:0]       mon_f;
    logic [7:0]       yr_f;
    logic [7:0]       last_day;

    assign day_f    = {2'b00, word_q[5:0]};
    assign mon_f    = {3'b000, word_q[12:8]};
    assign yr_f     = word_q[23:16];
    assign leap     = bcd_leap(yr_f);
    assign last_day = last_day_of(mon_f, leap);
    assign day_wrap = (day_f >= last_day);
    assign mon_wrap = (mon_f >= 8'h12);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= CAL_RESET;
            dow_q  <= '0;
        end else if (ld) begin
            word_q <= ld_word & CAL_MASK;
            dow_q  <= ld_dow;
        end else begin
            if (step_day) begin
                word_q[5:0] <= day_wrap ? 6'h01 : 6'(bcd_inc(day_f));
                dow_q       <= (dow_q == DOW_LAST) ? '0 : dow_q + DOW_W'(1);
            end
            if (step_mon)
                word_q[12:8] <= mon_wrap ? 5'h01 : 5'(bcd_inc(mon_f));
            if (step_year)
                word_q[23:16] <= (yr_f == 8'h99) ? 8'h00 : bcd_inc(yr_f);
        end
    end

    assign word = word_q;
    assign dow  = dow_q;

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import rtc_bcd_pkg::*;
#(
    parameter int DOW_COUNT = 7,
    parameter int DOW_W     = $clog2(DOW_COUNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic             hour_mode_24,
    input  logic             time_ld,
    input  logic [TW-1:0]    time_ld_word,
    input  logic             cal_ld,
    input  logic [CW-1:0]    cal_ld_word,
    input  logic [DOW_W-1:0] dow_ld_val,
    output logic [TW-1:0]    time_now,
    output logic [CW-1:0]    cal_now,
    output logic [DOW_W-1:0] dow_now,
    output logic             leap_year
);

    seq_state_e seq_state;
    logic       load_any;
    logic       sec_wrap, min_wrap, hour_wrap, day_wrap, mon_wrap;
    logic       step_sec, step_min, step_hour, step_day, step_mon, step_year;

    assign load_any = time_ld | cal_ld;

    rtc_tick_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sec_tick),
        .load_any  (load_any),
        .sec_wrap  (sec_wrap),
        .min_wrap  (min_wrap),
        .hour_wrap (hour_wrap),
        .day_wrap  (day_wrap),
        .mon_wrap  (mon_wrap),
        .step_sec  (step_sec),
        .step_min  (step_min),
        .step_hour (step_hour),
        .step_day  (step_day),
        .step_mon  (step_mon),
        .step_year (step_year),
        .state_o   (seq_state)
    );

    rtc_clock_word u_clock (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode24    (hour_mode_24),
        .ld        (time_ld),
        .ld_word   (time_ld_word),
        .step_sec  (step_sec),
        .step_min  (step_min),
        .step_hour (step_hour),
        .word      (time_now),
        .sec_wrap  (sec_wrap),
        .min_wrap  (min_wrap),
        .hour_wrap (hour_wrap)
    );

    rtc_date_word #(
        .DOW_COUNT (DOW_COUNT),
        .DOW_W     (DOW_W)
    ) u_date (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld        (cal_ld),
        .ld_word   (cal_ld_word),
        .ld_dow    (dow_ld_val),
        .step_day  (step_day),
        .step_mon  (step_mon),
        .step_year (step_year),
        .word      (cal_now),
        .dow       (dow_now),
        .leap      (leap_year),
        .day_wrap  (day_wrap),
        .mon_wrap  (mon_wrap)
    );

endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
    import rtc_bcd_pkg::*;
#(
    parameter int DOW_COUNT = 7,
    parameter int DOW_W     = $clog2(DOW_COUNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic             time_ld,
    input  logic [TW-1:0]    time_ld_word,
    input  logic             cal_ld,
    input  logic [CW-1:0]    cal_ld_word,
    input  logic [DOW_W-1:0] dow_ld_val,
    input  logic [TW-1:0]    time_now,
    input  logic [CW-1:0]    cal_now,
    input  logic [DOW_W-1:0] dow_now,
    input  seq_state_e       seq_state
);

    // R2
    time_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        time_ld |=> time_now == ($past(time_ld_word) & TIME_MASK));

    // R2
    cal_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_ld |=> (cal_now == ($past(cal_ld_word) & CAL_MASK)) && (dow_now == $past(dow_ld_val)));

    // R3
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && (time_ld || cal_ld)) |=> seq_state == SQ_IDLE);

    // R12
    busy_tick_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && seq_state != SQ_IDLE) |=> seq_state != SQ_SEC);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SQ_IDLE && !time_ld) |=> $stable(time_now));

    // R5
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SQ_SEC && !time_ld && !cal_ld && time_now[6:0] == 7'h59)
        |=> time_now[6:0] == 7'h00);

    // R11
    dow_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SQ_DAY && !time_ld && !cal_ld && dow_now == DOW_W'(DOW_COUNT - 1))
        |=> dow_now == '0);

endmodule

bind bcd_rtc_core rtc_core_chk #(
    .DOW_COUNT (DOW_COUNT),
    .DOW_W     (DOW_W)
) u_rtc_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sec_tick     (sec_tick),
    .time_ld      (time_ld),
    .time_ld_word (time_ld_word),
    .cal_ld       (cal_ld),
    .cal_ld_word  (cal_ld_word),
    .dow_ld_val   (dow_ld_val),
    .time_now     (time_now),
    .cal_now      (cal_now),
    .dow_now      (dow_now),
    .seq_state    (seq_state)
);

// File: tb/test_bcd_rtc_core.sv
module test_bcd_rtc_core;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        hour_mode_24 = 1'b1;
    logic        time_ld = 1'b0;
    logic [21:0] time_ld_word = '0;
    logic        cal_ld = 1'b0;
    logic [23:0] cal_ld_word = '0;
    logic [2:0]  dow_ld_val = '0;
    logic [21:0] time_now;
    logic [23:0] cal_now;
    logic [2:0]  dow_now;
    logic        leap_year;

    int total = 0;
    int bad = 0;

    // reference model state
    int ms, mm, mh, mpm, md, mmo, my, mdow;
    bit m24;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bcd_rtc_core i_bcd_rtc_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .sec_tick     (sec_tick),
        .hour_mode_24 (hour_mode_24),
        .time_ld      (time_ld),
        .time_ld_word (time_ld_word),
        .cal_ld       (cal_ld),
        .cal_ld_word  (cal_ld_word),
        .dow_ld_val   (dow_ld_val),
        .time_now     (time_now),
        .cal_now      (cal_now),
        .dow_now      (dow_now),
        .leap_year    (leap_year)
    );

    function automatic logic [7:0] i2b(int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int mdays(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [21:0] pack_time();
        logic [21:0] t = '0;
        logic [7:0]  hb = i2b(mh);
        logic [7:0]  mb = i2b(mm);
        logic [7:0]  sb = i2b(ms);
        t[21:16] = m24 ? hb[5:0] : {mpm[0], hb[4:0]};
        t[14:8]  = mb[6:0];
        t[6:0]   = sb[6:0];
        return t;
    endfunction

    function automatic logic [23:0] pack_cal();
        logic [7:0] db = i2b(md);
        logic [7:0] ob = i2b(mmo);
        return {i2b(my), 3'b000, ob[4:0], 2'b00, db[5:0]};
    endfunction

    task automatic model_tick();
        bit date_adv = 0;
        ms++;
        if (ms == 60) begin
            ms = 0;
            mm++;
            if (mm == 60) begin
                mm = 0;
                if (m24) begin
                    if (mh == 23) begin mh = 0; date_adv = 1; end
                    else mh++;
                end else if (mh == 11) begin
                    mh = 12;
                    if (mpm == 1) date_adv = 1;
                    mpm = 1 - mpm;
                end else if (mh == 12) mh = 1;
                else mh++;
            end
        end
        if (date_adv) begin
            mdow = (mdow + 1) % 7;
            md++;
            if (md > mdays(mmo, my)) begin
                md = 1;
                mmo++;
                if (mmo > 12) begin mmo = 1; my = (my + 1) % 100; end
            end
        end
    endtask

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk({tag, " time"}, 32'(time_now), 32'(pack_time()));
        chk({tag, " cal"},  32'(cal_now),  32'(pack_cal()));
        chk({tag, " dow"},  32'(dow_now),  32'(mdow));
        chk({tag, " leap R9"}, 32'(leap_year), 32'(my % 4 == 0));
    endtask

    task automatic set_model(bit f24, int h, int pm, int mi, int s, int d, int mo, int y, int w);
        m24 = f24; mh = h; mpm = pm; mm = mi; ms = s; md = d; mmo = mo; my = y; mdow = w;
    endtask

    task automatic load_model(string tag);
        @(negedge clk);
        hour_mode_24 = m24;
        time_ld = 1'b1; time_ld_word = pack_time();
        cal_ld = 1'b1;  cal_ld_word = pack_cal(); dow_ld_val = 3'(mdow);
        @(negedge clk);
        time_ld = 1'b0; cal_ld = 1'b0;
        check_all(tag);
    endtask

    task automatic tick_check(string tag);
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        repeat (8) @(negedge clk);
        model_tick();
        check_all(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        chk("R1 time", 32'(time_now), 32'h0);
        chk("R1 cal",  32'(cal_now),  32'h000101);
        chk("R1 dow",  32'(dow_now),  32'h0);
        chk("R1 leap", 32'(leap_year), 32'h1);

        // R2 load, gap bits forced to zero
        @(negedge clk);
        time_ld = 1'b1; time_ld_word = 22'h3FFFFF & 22'h12_B4_A5 | 22'h008080;
        @(negedge clk);
        time_ld = 1'b0;
        chk("R2 gap mask", 32'(time_now & 22'h008080), 32'h0);

        // R6 R10 R11 full rollover in 24h mode
        set_model(1, 23, 0, 59, 59, 31, 12, 99, 6);
        load_model("R2 load");
        tick_check("R6 R10 R11 midnight");
        chk("R10 year wrap", 32'(cal_now), 32'h000101);
        chk("R11 dow wrap", 32'(dow_now), 32'h0);

        // R8 month lengths and February
        set_model(1, 23, 0, 59, 59, 30, 4, 21, 2);
        load_model("R8 load");
        tick_check("R8 30-day month");
        set_model(1, 23, 0, 59, 59, 28, 2, 23, 3);
        load_model("R8 load");
        tick_check("R8 common feb");
        set_model(1, 23, 0, 59, 59, 28, 2, 24, 3);
        load_model("R8 load");
        tick_check("R8 leap feb 28");
        tick_check("R5 plain step");
        set_model(1, 23, 0, 59, 59, 29, 2, 24, 4);
        load_model("R8 load");
        tick_check("R8 leap feb 29");

        // R7 12-hour mode
        set_model(0, 11, 0, 59, 59, 15, 6, 30, 1);
        load_model("R7 load");
        tick_check("R7 am to pm noon");
        chk("R7 noon word", 32'(time_now), 32'h320000);
        set_model(0, 12, 1, 59, 59, 15, 6, 30, 1);
        load_model("R7 load");
        tick_check("R7 12 to 01");
        set_model(0, 11, 1, 59, 59, 15, 6, 30, 1);
        load_model("R7 load");
        tick_check("R7 pm midnight");
        chk("R7 midnight word", 32'(time_now), 32'h120000);

        // R3 load wins over a simultaneous tick
        set_model(1, 10, 0, 0, 59, 5, 5, 5, 5);
        @(negedge clk);
        hour_mode_24 = 1'b1;
        sec_tick = 1'b1;
        time_ld = 1'b1; time_ld_word = pack_time();
        cal_ld = 1'b1;  cal_ld_word = pack_cal(); dow_ld_val = 3'(mdow);
        @(negedge clk);
        sec_tick = 1'b0; time_ld = 1'b0; cal_ld = 1'b0;
        repeat (8) @(negedge clk);
        check_all("R3 tick dropped");

        // R12 second tick during ripple ignored
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk);
        @(negedge clk); sec_tick = 1'b0;
        repeat (8) @(negedge clk);
        model_tick();
        check_all("R12 busy tick");

        // R4 R5 constrained random with carry-biased loads
        for (int it = 0; it < 60; it++) begin
            bit f24 = 1'($urandom % 2);
            int y = ($urandom % 4 == 0) ? 99 : int'($urandom % 100);
            int mo = ($urandom % 3 == 0) ? 12 : (($urandom % 3 == 0) ? 2 : 1 + int'($urandom % 12));
            int d = ($urandom % 2 == 0) ? mdays(mo, y) : 1 + int'($urandom % mdays(mo, y));
            int h = f24 ? (($urandom % 2 == 0) ? 23 : int'($urandom % 24))
                        : (($urandom % 2 == 0) ? 11 : 1 + int'($urandom % 12));
            int mi = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
            int s = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
            set_model(f24, h, int'($urandom % 2), mi, s, d, mo, y, int'($urandom % 7));
            load_model("R2 random load");
            for (int k = 0; k < 1 + int'($urandom % 3); k++)
                tick_check("R4 R5 random tick");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule